// File: doc/BRIEF.md
# I2C Target with Address Matching

This block is the receiving end of a two-wire serial bus. It watches the clock and data lines through glitch filters and finds START and STOP conditions. It shifts serial bits, most significant first, into an internal shift register. When a transfer names this device, the block acknowledges it and then exchanges data bytes with a host through a one-byte receive buffer and a transmit data input.

The block answers to a 7-bit or a 10-bit own address, chosen by a mode input. It also answers to the general call address. It keeps sticky START and STOP flags, which the host reads to tell whether the bus is busy or free. A single-cycle interrupt pulse tells the host that an address has matched, that a byte has finished or that a STOP was seen. The data line is open-drain: the block only ever pulls it low, through an output enable. The clock line is an input only.

Top module: `i2c_target`

## Requirements
- R1: A level change on either bus line reaches the block only after it has held for FILT_CYC consecutive system clocks. A pulse shorter than that has no effect: a 3-clock low pulse on the data line while the clock line is high leaves `bus_s` and `bus_p` unchanged.
- R2: After reset `bus_s` and `bus_p` are 0. A START sets `bus_s` and clears `bus_p`. A STOP sets `bus_p` and clears `bus_s`. The two flags are never both 1.
- R3: In 7-bit mode (`mode_10b`=0), the first byte after a START matches when its bits 7:1 equal `own_addr[6:0]`. On a match the block pulls the data line low during the 9th clock (ACK), sets `addr_hit`, and sets `rd_mode` equal to bit 0 of the byte (1 = read).
- R4: An address byte that does not match is answered with NACK (data line left high). The following bytes of that transfer are ignored: they get no ACK and leave `rx_full` at 0.
- R5: With GC_EN=1, a first byte of 0x00 is acknowledged in either mode, and it sets `gen_call` and `addr_hit`. The data bytes that follow are then received.
- R6: In 10-bit mode, a first byte equal to 11110, then `own_addr[9:8]`, then a 0 bit is acknowledged without setting `addr_hit`. A second byte equal to `own_addr[7:0]` is then acknowledged and sets `addr_hit`. Any other second byte gets NACK.
- R7: In 10-bit mode, a read header (11110, `own_addr[9:8]`, 1) is acknowledged only after a repeated START that follows a full 10-bit match with no STOP in between. It then sets `rd_mode` and starts transmitting. After a STOP the same header gets NACK.
- R8: A received data byte is placed in `rx_data` MSb first and sets `rx_full`, and the block ACKs it. A one-cycle `rx_ack` pulse clears `rx_full` and `ovf`.
- R9: A byte that completes while `rx_full` is 1 (and `rx_ack` is not 1 in that cycle) sets `ovf`. It gets NACK and leaves `rx_data` unchanged.
- R10: In a read, `tx_data` is sampled at the end of the address ACK and at the end of each master ACK. It is sent MSb first. A master NACK ends the transmission and releases the data line.
- R11: `irq` pulses for exactly one cycle on each address match, each completed data byte (received and stored, or transmitted), and each STOP.
- R12: The data line is controlled only through `sda_oe` (1 = pull low). `sda_oe` changes only while the filtered clock is low, or on a START or STOP. It is 0 after reset and after a STOP.
- R13: When a byte completes in the same cycle as an `rx_ack` pulse while `rx_full` is 1, the host read wins: the new byte is stored and acknowledged, `rx_full` stays 1, and `ovf` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| own_addr | input | 10 | Own address (bits 6:0 used in 7-bit mode) |
| mode_10b | input | 1 | 1 selects 10-bit addressing |
| tx_data | input | 8 | Byte to transmit on reads |
| rx_data | output | 8 | Last received data byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ack | input | 1 | Host has read the buffer (pulse) |
| ovf | output | 1 | Byte lost because the buffer was full |
| addr_hit | output | 1 | Address matched in the current transfer |
| gen_call | output | 1 | General call address received |
| rd_mode | output | 1 | Current transfer is a read |
| bus_s | output | 1 | Sticky START seen |
| bus_p | output | 1 | Sticky STOP seen |
| irq | output | 1 | One-cycle event pulse |

## Verification
A host read of the receive buffer and the completion of a new byte can land in the same cycle. In that cycle one path clears the buffer-full flag and the other sets it or raises overflow. The bench knows the exact latency of the filter and edge detectors. It uses that to pulse `rx_ack` on the precise clock in which the filtered 8th rising clock edge is seen, with an earlier byte still unread. It judges the outcome at the ports: the master must see ACK, `rx_data` must hold the new byte, `rx_full` must be 1 and `ovf` must be 0.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR1, ST_ADDR2, ST_RX, ST_TX, ST_ACK, ST_MACK
   } i2ct_state_e;
   localparam logic [4:0] HDR10 = 5'b11110;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2ct_deglitch.sv
module i2ct_deglitch #(
   parameter int STABLE_CYC = 4,
   parameter bit RESET_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic filt_o
);
   localparam int CW = $clog2(STABLE_CYC);

   generate
      if (STABLE_CYC < 2) begin : g_bad_len
         $error("STABLE_CYC must be at least 2");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic [CW-1:0] cnt_q;
   logic          filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {2{RESET_VAL}};
         cnt_q  <= '0;
         filt_q <= RESET_VAL;
      end else begin
         sync_q <= {sync_q[0], pin_i};
         if (sync_q[1] == filt_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
            filt_q <= sync_q[1];
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign filt_o = filt_q;

   // R1: filtered level moves only after a full run of disagreeing samples
   a_r1_full_run: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CW'(STABLE_CYC - 1)));
endmodule

// File: rtl/i2ct_addr_cmp.sv
module i2ct_addr_cmp
   import i2ct_pkg::*;
#(
   parameter bit GC_EN = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [9:0]        own_i,
   output logic              hit7_o,
   output logic              hdr10_o,
   output logic              lo10_o,
   output logic              gcall_o
);
   assign hit7_o  = (byte_i[7:1] == own_i[6:0]);
   assign hdr10_o = (byte_i[7:3] == HDR10) && (byte_i[2:1] == own_i[9:8]);
   assign lo10_o  = (byte_i == own_i[7:0]);

   generate
      if (GC_EN) begin : g_gc
         assign gcall_o = (byte_i == '0);
      end else begin : g_no_gc
         assign gcall_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_target.sv
module i2c_target
   import i2ct_pkg::*;
#(
   parameter int FILT_CYC = 4,
   parameter bit GC_EN    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_oe,
   input  logic [9:0]  own_addr,
   input  logic        mode_10b,
   input  logic [7:0]  tx_data,
   output logic [7:0]  rx_data,
   output logic        rx_full,
   input  logic        rx_ack,
   output logic        ovf,
   output logic        addr_hit,
   output logic        gen_call,
   output logic        rd_mode,
   output logic        bus_s,
   output logic        bus_p,
   output logic        irq
);
   localparam int LINES = 2;
   localparam int CNT_W = $clog2(BYTE_W);

   logic [LINES-1:0] raw, filt;
   assign raw = {scl_i, sda_i};

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         i2ct_deglitch #(.STABLE_CYC(FILT_CYC), .RESET_VAL(1'b1)) u_flt (
            .clk(clk), .rst_n(rst_n), .pin_i(raw[i]), .filt_o(filt[i]));
      end
   endgenerate

   logic scl_f, sda_f, scl_d, sda_d;
   assign scl_f = filt[1];
   assign sda_f = filt[0];

   logic scl_rise, scl_fall, start, stop;
   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start    = scl_f & scl_d & sda_d & ~sda_f;
   assign stop     = scl_f & scl_d & ~sda_d & sda_f;

   i2ct_state_e st_q, nxt_q;
   logic             ph_q, ack_q, mack_q, sda_oe_q;
   logic [CNT_W-1:0] cnt_q;
   logic [6:0]       sh_q, tx_q;
   logic [7:0]       buf_q;
   logic             full_q, ovf_q, hit_q, gc_q, rd_q, hi_ok_q, s_q, p_q, irq_q;

   logic [BYTE_W-1:0] nb;
   assign nb = {sh_q, sda_f};

   logic hit7, hdr10, lo10, gcall;
   i2ct_addr_cmp #(.GC_EN(GC_EN)) u_cmp (
      .byte_i(nb), .own_i(own_addr), .hit7_o(hit7), .hdr10_o(hdr10),
      .lo10_o(lo10), .gcall_o(gcall));

   // decision taken when the 8th bit of a received byte is sampled
   logic d_ack, d_hit, d_gc, d_rd, d_hiok, d_store, d_ovf;
   i2ct_state_e d_nxt;
   always_comb begin
      d_ack = 1'b0; d_hit = 1'b0; d_gc = 1'b0; d_rd = 1'b0;
      d_hiok = 1'b0; d_store = 1'b0; d_ovf = 1'b0; d_nxt = ST_IDLE;
      case (st_q)
         ST_ADDR1: begin
            if (gcall) begin
               d_ack = 1'b1; d_hit = 1'b1; d_gc = 1'b1; d_nxt = ST_RX;
            end else if (!mode_10b && hit7) begin
               d_ack = 1'b1; d_hit = 1'b1; d_rd = nb[0];
               d_nxt = nb[0] ? ST_TX : ST_RX;
            end else if (mode_10b && hdr10 && !nb[0]) begin
               d_ack = 1'b1; d_nxt = ST_ADDR2;
            end else if (mode_10b && hdr10 && hi_ok_q) begin
               d_ack = 1'b1; d_hit = 1'b1; d_rd = 1'b1; d_nxt = ST_TX;
            end
         end
         ST_ADDR2: begin
            if (lo10) begin
               d_ack = 1'b1; d_hit = 1'b1; d_hiok = 1'b1; d_nxt = ST_RX;
            end
         end
         ST_RX: begin
            if (full_q && !rx_ack) begin
               d_ovf = 1'b1;
            end else begin
               d_store = 1'b1; d_ack = 1'b1; d_nxt = ST_RX;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; nxt_q <= ST_IDLE; ph_q <= 1'b0; ack_q <= 1'b0;
         mack_q <= 1'b0; sda_oe_q <= 1'b0; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
         buf_q <= '0; full_q <= 1'b0; ovf_q <= 1'b0; hit_q <= 1'b0; gc_q <= 1'b0;
         rd_q <= 1'b0; hi_ok_q <= 1'b0; s_q <= 1'b0; p_q <= 1'b0; irq_q <= 1'b0;
         scl_d <= 1'b1; sda_d <= 1'b1;
      end else begin
         irq_q <= 1'b0;
         scl_d <= scl_f;
         sda_d <= sda_f;
         if (rx_ack) begin
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
         end
         if (start) begin
            st_q <= ST_ADDR1; cnt_q <= '0; ph_q <= 1'b0; sda_oe_q <= 1'b0;
            s_q <= 1'b1; p_q <= 1'b0; hit_q <= 1'b0; gc_q <= 1'b0; rd_q <= 1'b0;
         end else if (stop) begin
            st_q <= ST_IDLE; sda_oe_q <= 1'b0; s_q <= 1'b0; p_q <= 1'b1;
            hit_q <= 1'b0; gc_q <= 1'b0; rd_q <= 1'b0; hi_ok_q <= 1'b0; irq_q <= 1'b1;
         end else if (scl_rise) begin
            case (st_q)
               ST_ADDR1, ST_ADDR2, ST_RX: begin
                  sh_q  <= nb[6:0];
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                     st_q <= ST_ACK; ph_q <= 1'b0; ack_q <= d_ack; nxt_q <= d_nxt;
                     if (d_hit)  hit_q   <= 1'b1;
                     if (d_gc)   gc_q    <= 1'b1;
                     if (d_rd)   rd_q    <= 1'b1;
                     if (d_hiok) hi_ok_q <= 1'b1;
                     if (d_ovf)  ovf_q   <= 1'b1;
                     if (d_store) begin
                        buf_q  <= nb;
                        full_q <= 1'b1;
                     end
                     irq_q <= d_hit | d_store;
                  end
               end
               ST_TX: begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                     st_q <= ST_MACK; ph_q <= 1'b0; irq_q <= 1'b1;
                  end
               end
               ST_MACK: if (ph_q) mack_q <= ~sda_f;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (st_q)
               ST_ACK: begin
                  if (!ph_q) begin
                     sda_oe_q <= ack_q; ph_q <= 1'b1;
                  end else begin
                     ph_q <= 1'b0; cnt_q <= '0; st_q <= nxt_q;
                     if (nxt_q == ST_TX) begin
                        tx_q <= tx_data[6:0]; sda_oe_q <= ~tx_data[7];
                     end else begin
                        sda_oe_q <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  tx_q     <= {tx_q[5:0], 1'b0};
                  sda_oe_q <= ~tx_q[6];
               end
               ST_MACK: begin
                  if (!ph_q) begin
                     sda_oe_q <= 1'b0; ph_q <= 1'b1;
                  end else begin
                     ph_q <= 1'b0; cnt_q <= '0;
                     if (mack_q) begin
                        tx_q <= tx_data[6:0]; sda_oe_q <= ~tx_data[7]; st_q <= ST_TX;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = sda_oe_q;
   assign rx_data  = buf_q;
   assign rx_full  = full_q;
   assign ovf      = ovf_q;
   assign addr_hit = hit_q;
   assign gen_call = gc_q;
   assign rd_mode  = rd_q;
   assign bus_s    = s_q;
   assign bus_p    = p_q;
   assign irq      = irq_q;

   // R2: start and stop flags are mutually exclusive
   a_r2_sp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_q && p_q));
   // R9: overflow only rises when the buffer was already occupied
   a_r9_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(full_q));
   // R11: event pulse lasts one cycle
   a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   // R12: data line drive moves only in the low clock phase or on a bus condition
   a_r12_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_q) |-> $past(!scl_f || start || stop));
endmodule

// File: tb/i2c_target_test.sv
module i2c_target_test;
   localparam int FL = 4;
   localparam int Q  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic [9:0] own_addr = 10'h052;
   logic mode_10b = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic rx_ack = 1'b0;
   logic sda_oe, rx_full, ovf, addr_hit, gen_call, rd_mode, bus_s, bus_p, irq;
   logic [7:0] rx_data;
   logic scl_line, sda_line;

   assign scl_line = ~m_scl_low;
   assign sda_line = ~(m_sda_low | sda_oe);

   always #5 clk = ~clk;

   i2c_target #(.FILT_CYC(FL), .GC_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
      .own_addr(own_addr), .mode_10b(mode_10b), .tx_data(tx_data), .rx_data(rx_data),
      .rx_full(rx_full), .rx_ack(rx_ack), .ovf(ovf), .addr_hit(addr_hit),
      .gen_call(gen_call), .rd_mode(rd_mode), .bus_s(bus_s), .bus_p(bus_p), .irq(irq));

   int checks = 0, errors = 0, irq_cnt = 0, exp_irq = 0;
   logic [7:0] exp_q[$];

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda_low = 1'b1; wq(2*Q); m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic bus_rstart();
      m_sda_low = 1'b0; wq(Q); m_scl_low = 1'b0; wq(Q);
      m_sda_low = 1'b1; wq(Q); m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; wq(Q); m_scl_low = 1'b0; wq(2*Q); m_sda_low = 1'b0; wq(2*Q);
   endtask

   task automatic wr_bit(input logic b, input logic pulse);
      m_sda_low = ~b; wq(Q); m_scl_low = 1'b0;
      if (pulse) begin
         // filtered rising edge reaches the core FL+3 edges after release
         wq(FL + 2); rx_ack = 1'b1; wq(1); rx_ack = 1'b0; wq(2*Q - FL - 3);
      end else begin
         wq(2*Q);
      end
      m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, input logic pulse, output logic nak);
      for (int i = 7; i >= 0; i--) wr_bit(b[i], pulse && (i == 0));
      m_sda_low = 1'b0; wq(Q); m_scl_low = 1'b0; wq(Q);
      nak = sda_line; wq(Q); m_scl_low = 1'b1; wq(Q);
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] b);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         m_sda_low = 1'b0; wq(Q); m_scl_low = 1'b0; wq(Q);
         b = {b[6:0], sda_line}; wq(Q); m_scl_low = 1'b1; wq(Q);
      end
      m_sda_low = mack; wq(Q); m_scl_low = 1'b0; wq(2*Q); m_scl_low = 1'b1; wq(Q);
      m_sda_low = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all-R actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic nak;
      logic [7:0] rb;
      wq(5); rst_n = 1'b1; wq(3);
      // reset state
      chk("R2 reset bus_s", bus_s, 0);
      chk("R2 reset bus_p", bus_p, 0);
      chk("R12 reset sda_oe", sda_oe, 0);
      chk("R8 reset rx_full", rx_full, 0);

      // R1: short data pulse under high clock is rejected
      m_sda_low = 1'b1; wq(FL - 1); m_sda_low = 1'b0; wq(20);
      chk("R1 glitch bus_s", bus_s, 0);
      chk("R1 glitch bus_p", bus_p, 0);
      // R1: long pulse passes as START then STOP
      m_sda_low = 1'b1; wq(2*FL); m_sda_low = 1'b0; wq(20);
      exp_irq += 1;
      chk("R1 long pulse bus_p", bus_p, 1);
      chk("R11 irq after stop", irq_cnt, exp_irq);

      // 7-bit write with overflow
      bus_start();
      chk("R2 start bus_s", bus_s, 1);
      chk("R2 start bus_p", bus_p, 0);
      wr_byte(8'hA4, 1'b0, nak);
      chk("R3 addr ack", nak, 0);
      chk("R3 addr_hit", addr_hit, 1);
      chk("R3 rd_mode write", rd_mode, 0);
      exp_q.push_back(8'h3C);
      wr_byte(8'h3C, 1'b0, nak);
      chk("R8 data ack", nak, 0);
      chk("R8 rx_full", rx_full, 1);
      chk("R8 rx_data", rx_data, exp_q.pop_front());
      wr_byte(8'h99, 1'b0, nak);
      chk("R9 overflow nack", nak, 1);
      chk("R9 ovf flag", ovf, 1);
      chk("R9 rx_data kept", rx_data, 8'h3C);
      bus_stop();
      exp_irq += 3;
      chk("R2 stop bus_p", bus_p, 1);
      chk("R2 stop bus_s", bus_s, 0);
      chk("R12 released after stop", sda_oe, 0);
      rx_ack = 1'b1; wq(1); rx_ack = 1'b0; wq(2);
      chk("R8 rx_ack clears full", rx_full, 0);
      chk("R8 rx_ack clears ovf", ovf, 0);

      // R4: wrong address
      bus_start();
      wr_byte(8'hA6, 1'b0, nak);
      chk("R4 mismatch nack", nak, 1);
      chk("R4 no addr_hit", addr_hit, 0);
      wr_byte(8'h11, 1'b0, nak);
      chk("R4 later byte nack", nak, 1);
      chk("R4 buffer untouched", rx_full, 0);
      bus_stop();
      exp_irq += 1;

      // R5: general call
      bus_start();
      wr_byte(8'h00, 1'b0, nak);
      chk("R5 gc ack", nak, 0);
      chk("R5 gen_call flag", gen_call, 1);
      wr_byte(8'h5A, 1'b0, nak);
      chk("R5 gc data", rx_data, 8'h5A);
      bus_stop();
      exp_irq += 3;
      rx_ack = 1'b1; wq(1); rx_ack = 1'b0; wq(2);

      // R13: host read meets byte completion in one cycle
      bus_start();
      wr_byte(8'hA4, 1'b0, nak);
      wr_byte(8'h81, 1'b0, nak);
      chk("R13 first byte held", rx_full, 1);
      wr_byte(8'h7E, 1'b1, nak);
      chk("R13 ack when read meets completion", nak, 0);
      chk("R13 new byte stored", rx_data, 8'h7E);
      chk("R13 full stays", rx_full, 1);
      chk("R13 no overflow", ovf, 0);
      bus_stop();
      exp_irq += 4;
      rx_ack = 1'b1; wq(1); rx_ack = 1'b0; wq(2);

      // R10: 7-bit read of two bytes
      tx_data = 8'hC5;
      bus_start();
      wr_byte(8'hA5, 1'b0, nak);
      chk("R3 read addr ack", nak, 0);
      chk("R3 rd_mode read", rd_mode, 1);
      tx_data = 8'h3B;
      rd_byte(1'b1, rb);
      chk("R10 first tx byte", rb, 8'hC5);
      rd_byte(1'b0, rb);
      chk("R10 second tx byte", rb, 8'h3B);
      chk("R10 released after nack", sda_oe, 0);
      bus_stop();
      exp_irq += 4;

      // R6/R7: 10-bit addressing
      mode_10b = 1'b1; own_addr = 10'h2A5; tx_data = 8'h96;
      bus_start();
      wr_byte(8'hF4, 1'b0, nak);
      chk("R6 header ack", nak, 0);
      chk("R6 no hit after header", addr_hit, 0);
      wr_byte(8'hA5, 1'b0, nak);
      chk("R6 low byte ack", nak, 0);
      chk("R6 hit after low byte", addr_hit, 1);
      wr_byte(8'h42, 1'b0, nak);
      chk("R6 data in 10-bit", rx_data, 8'h42);
      rx_ack = 1'b1; wq(1); rx_ack = 1'b0;
      bus_rstart();
      wr_byte(8'hF5, 1'b0, nak);
      chk("R7 read header ack", nak, 0);
      chk("R7 rd_mode", rd_mode, 1);
      rd_byte(1'b0, rb);
      chk("R7 tx byte", rb, 8'h96);
      bus_stop();
      exp_irq += 5;

      bus_start();
      wr_byte(8'hF4, 1'b0, nak);
      wr_byte(8'hA4, 1'b0, nak);
      chk("R6 wrong low byte nack", nak, 1);
      chk("R6 wrong low byte no hit", addr_hit, 0);
      bus_stop();
      exp_irq += 1;

      bus_start();
      wr_byte(8'hF5, 1'b0, nak);
      chk("R7 read header without match nack", nak, 1);
      bus_stop();
      exp_irq += 1;

      chk("R11 irq total", irq_cnt, exp_irq);
      chk("R4 buffer still empty", rx_full, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule